// File: doc/BRIEF.md
# Ternary Route Match Table with Entry Status

This block is a small ternary lookup table for forwarding engines. Every slot stores a key value, a care mask (a mask bit of 0 makes that key bit a don't-care) and a two-bit status. A lookup port copies a search key into an internal compare register. One cycle later it reports the lowest-indexed matching slot and raises a match flag. The result stays on the outputs until a downstream acknowledge pulse says that the index has been captured.

A separate maintenance port writes slots, deletes them, or marks them as being rewritten. It never stalls the lookup path. A slot that has just produced a hit is locked against maintenance until the acknowledge arrives. When the winning slot is marked as being rewritten, the match flag rises but the index is withheld and the key stays held. The index is released on the cycle after the rewrite completes. A free-slot output always names the lowest-indexed empty slot, so that inserts need no reordering.

Top module: `tcam_route_table`

## Requirements
- R1: After reset every slot is empty: `next_free` is 0, `table_full` is 0, and `match_flag`, `result_valid` and `search_busy` are 0.
- R2: A slot matches when `(key ^ value) & mask` is zero, so a mask bit of 0 matches either key bit.
- R3: Empty slots never match. The delete command (`maint_cmd` = 2'b10) empties a non-locked slot.
- R4: When several slots match, the lowest index is reported.
- R5: A `search_req` accepted at edge A is compared at edge A+1. On a hit, `match_flag` and `result_valid` go to 1 with `result_idx` set, and they hold until `result_ack` is sampled high. They are 0 after that edge, and `search_busy` returns to 0.
- R6: While a slot holds an unacknowledged hit, write, delete and mark commands addressed to it have no effect.
- R7: If the winning slot is in the updating state (set by mark, `maint_cmd` = 2'b11), `match_flag` is 1 and `result_valid` stays 0. The index is delivered one edge after the write command (`maint_cmd` = 2'b01) that completes the slot.
- R8: A new key is loaded only while `search_busy` is 0. Requests made while busy are ignored, and the held key is the one that gets compared.
- R9: On a miss, `result_valid` is 1 for exactly one cycle with `match_flag` 0, and `search_busy` is 0 in that cycle.
- R10: `next_free` is the lowest-indexed empty slot. `table_full` is 1 exactly when no slot is empty.
- R11: Maintenance to other slots takes effect while a lookup is in flight, without disturbing that lookup.
- R12: If a compare hits a slot in the same edge that a maintenance command targets it, the hit wins and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| search_req | input | 1 | Request to load `search_key` |
| search_key | input | KEY_W | Lookup key |
| search_busy | output | 1 | Compare register occupied |
| match_flag | output | 1 | A slot matches the held key |
| result_valid | output | 1 | Result presented (hit or miss) |
| result_idx | output | IDX_W | Winning slot index |
| result_ack | input | 1 | Downstream has captured the index |
| maint_cmd | input | 2 | 00 none, 01 write, 10 delete, 11 mark updating |
| maint_idx | input | IDX_W | Target slot |
| maint_value | input | KEY_W | Value for write |
| maint_mask | input | KEY_W | Care mask for write |
| next_free | output | IDX_W | Lowest empty slot |
| table_full | output | 1 | No slot is empty |

## Verification
Two functions can meet in one edge: the compare that turns a slot into a locked hit, and a maintenance command aimed at that same slot. The bench provokes this by issuing a delete on exactly the compare edge of a lookup. It judges the outcome by checking three things: the hit is reported, `next_free` does not move, and a repeat lookup still finds the slot. A second overlap, a rewrite that completes while a suspended lookup waits, is judged by the exact edge on which the index appears.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [1:0] {
    ST_INVALID  = 2'b00,
    ST_VALID    = 2'b01,
    ST_HIT      = 2'b10,
    ST_UPDATING = 2'b11
  } slot_state_e;

  typedef enum logic [1:0] {
    MC_NOP    = 2'b00,
    MC_WRITE  = 2'b01,
    MC_DELETE = 2'b10,
    MC_MARK   = 2'b11
  } maint_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_CMP  = 2'b01,
    PH_WAIT = 2'b10
  } search_phase_e;
endpackage

// File: rtl/tcam_slot.sv
module tcam_slot
  import tcam_pkg::*;
#(
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] cmp_key,
  input  logic             cmd_en,
  input  maint_cmd_e       cmd,
  input  logic [KEY_W-1:0] cmd_value,
  input  logic [KEY_W-1:0] cmd_mask,
  input  logic             hit_set,
  input  logic             hit_release,
  output slot_state_e      state_o,
  output logic             match_o
);
  logic [KEY_W-1:0] value_q, mask_q;
  slot_state_e      state_q;

  function automatic logic ternary_eq(input logic [KEY_W-1:0] k,
                                      input logic [KEY_W-1:0] v,
                                      input logic [KEY_W-1:0] m);
    return ((k ^ v) & m) == '0;
  endfunction

  assign state_o = state_q;
  assign match_o = (state_q != ST_INVALID) && ternary_eq(cmp_key, value_q, mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_INVALID;
      value_q <= '0;
      mask_q  <= '0;
    end else if (hit_set) begin
      state_q <= ST_HIT;
    end else if (hit_release && state_q == ST_HIT) begin
      state_q <= ST_VALID;
    end else if (cmd_en && state_q != ST_HIT) begin
      case (cmd)
        MC_WRITE: begin
          value_q <= cmd_value;
          mask_q  <= cmd_mask;
          state_q <= ST_VALID;
        end
        MC_DELETE: state_q <= ST_INVALID;
        MC_MARK:   if (state_q != ST_INVALID) state_q <= ST_UPDATING;
        default:   state_q <= state_q;
      endcase
    end
  end

  // R6
  hit_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HIT && !hit_release) |=> state_q == ST_HIT);

  // R3
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd == MC_DELETE && state_q != ST_HIT && !hit_set)
      |=> (state_q == ST_INVALID && !match_o));
endmodule

// File: rtl/tcam_low_pick.sv
module tcam_low_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign found = |req;
endmodule

// File: rtl/tcam_search_ctl.sv
module tcam_search_ctl
  import tcam_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             search_req,
  input  logic [KEY_W-1:0] search_key,
  input  logic             win_found,
  input  logic [IDX_W-1:0] win_idx,
  input  slot_state_e      win_state,
  input  logic             result_ack,
  output logic [KEY_W-1:0] cr_key,
  output logic             busy,
  output logic             match_flag,
  output logic             result_valid,
  output logic [IDX_W-1:0] result_idx,
  output logic             hit_set,
  output logic [IDX_W-1:0] hit_idx,
  output logic             release_pulse
);
  search_phase_e phase_q;

  assign busy          = phase_q != PH_IDLE;
  assign hit_set       = phase_q == PH_CMP && win_found && win_state == ST_VALID;
  assign hit_idx       = win_idx;
  assign release_pulse = phase_q == PH_WAIT && result_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      cr_key       <= '0;
      match_flag   <= 1'b0;
      result_valid <= 1'b0;
      result_idx   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          result_valid <= 1'b0;
          if (search_req) begin
            cr_key  <= search_key;
            phase_q <= PH_CMP;
          end
        end
        PH_CMP: begin
          if (win_found) begin
            match_flag <= 1'b1;
            if (win_state == ST_VALID) begin
              result_valid <= 1'b1;
              result_idx   <= win_idx;
              phase_q      <= PH_WAIT;
            end
          end else begin
            match_flag   <= 1'b0;
            result_valid <= 1'b1;
            result_idx   <= '0;
            phase_q      <= PH_IDLE;
          end
        end
        PH_WAIT: begin
          if (result_ack) begin
            match_flag   <= 1'b0;
            result_valid <= 1'b0;
            phase_q      <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R8
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cr_key));

  // R9
  miss_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !match_flag) |=> !result_valid || busy);
endmodule

// File: rtl/tcam_route_table.sv
module tcam_route_table
  import tcam_pkg::*;
#(
  parameter int N     = 8,
  parameter int KEY_W = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             search_req,
  input  logic [KEY_W-1:0] search_key,
  output logic             search_busy,
  output logic             match_flag,
  output logic             result_valid,
  output logic [IDX_W-1:0] result_idx,
  input  logic             result_ack,
  input  logic [1:0]       maint_cmd,
  input  logic [IDX_W-1:0] maint_idx,
  input  logic [KEY_W-1:0] maint_value,
  input  logic [KEY_W-1:0] maint_mask,
  output logic [IDX_W-1:0] next_free,
  output logic             table_full
);
  logic [KEY_W-1:0] cr_key;
  slot_state_e      slot_state [N];
  logic [N-1:0]     slot_match;
  logic [N-1:0]     slot_empty;
  logic             win_found, free_found;
  logic [IDX_W-1:0] win_idx, hit_idx;
  logic             hit_set, release_pulse;
  maint_cmd_e       cmd_e;

  assign cmd_e = maint_cmd_e'(maint_cmd);

  for (genvar g = 0; g < N; g++) begin : g_slot
    tcam_slot #(.KEY_W(KEY_W)) slot_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmp_key    (cr_key),
      .cmd_en     (cmd_e != MC_NOP && maint_idx == IDX_W'(g)),
      .cmd        (cmd_e),
      .cmd_value  (maint_value),
      .cmd_mask   (maint_mask),
      .hit_set    (hit_set && hit_idx == IDX_W'(g)),
      .hit_release(release_pulse && result_idx == IDX_W'(g)),
      .state_o    (slot_state[g]),
      .match_o    (slot_match[g])
    );
    assign slot_empty[g] = slot_state[g] == ST_INVALID;
  end

  tcam_low_pick #(.N(N), .IDX_W(IDX_W)) win_pick_i (
    .req(slot_match), .found(win_found), .idx(win_idx));

  tcam_low_pick #(.N(N), .IDX_W(IDX_W)) free_pick_i (
    .req(slot_empty), .found(free_found), .idx(next_free));

  assign table_full = !free_found;

  tcam_search_ctl #(.KEY_W(KEY_W), .IDX_W(IDX_W)) ctl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .search_req   (search_req),
    .search_key   (search_key),
    .win_found    (win_found),
    .win_idx      (win_idx),
    .win_state    (slot_state[win_idx]),
    .result_ack   (result_ack),
    .cr_key       (cr_key),
    .busy         (search_busy),
    .match_flag   (match_flag),
    .result_valid (result_valid),
    .result_idx   (result_idx),
    .hit_set      (hit_set),
    .hit_idx      (hit_idx),
    .release_pulse(release_pulse)
  );

  // R5
  hit_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && match_flag) |-> slot_state[result_idx] == ST_HIT);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && match_flag && !result_ack)
      |=> (result_valid && match_flag && $stable(result_idx)));

  // R10
  free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !table_full |-> slot_state[next_free] == ST_INVALID);

  // R4
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_found |-> (slot_match[win_idx] &&
                   (slot_match & ((N'(1) << win_idx) - N'(1))) == '0));

  // R7
  suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (search_busy && win_found && slot_state[win_idx] == ST_UPDATING && !result_valid)
      |=> (match_flag && !result_valid));
endmodule

// File: tb/tcam_route_table_tb.sv
module tcam_route_table_tb_top;
  localparam int N = 8, KEY_W = 16, IDX_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic search_req = 1'b0, result_ack = 1'b0;
  logic [KEY_W-1:0] search_key = '0, maint_value = '0, maint_mask = '0;
  logic [1:0] maint_cmd = 2'b00;
  logic [IDX_W-1:0] maint_idx = '0;
  logic search_busy, match_flag, result_valid, table_full;
  logic [IDX_W-1:0] result_idx, next_free;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tcam_route_table #(.N(N), .KEY_W(KEY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .search_req(search_req), .search_key(search_key),
    .search_busy(search_busy), .match_flag(match_flag), .result_valid(result_valid),
    .result_idx(result_idx), .result_ack(result_ack), .maint_cmd(maint_cmd),
    .maint_idx(maint_idx), .maint_value(maint_value), .maint_mask(maint_mask),
    .next_free(next_free), .table_full(table_full));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic maint(input logic [1:0] c, input int i, input logic [15:0] v, input logic [15:0] m);
    maint_cmd = c; maint_idx = IDX_W'(i); maint_value = v; maint_mask = m;
    tick();
    maint_cmd = 2'b00;
  endtask

  task automatic launch(input logic [15:0] k);
    search_req = 1'b1; search_key = k;
    tick();
    search_req = 1'b0;
    tick();
  endtask

  task automatic ack();
    result_ack = 1'b1;
    tick();
    result_ack = 1'b0;
  endtask

  task automatic expect_hit(input string rq, input logic [15:0] k, input int idx);
    launch(k);
    chk(rq, {match_flag, result_valid}, 2'b11);
    chk(rq, result_idx, idx);
    ack();
  endtask

  task automatic expect_miss(input string rq, input logic [15:0] k);
    launch(k);
    chk(rq, {result_valid, match_flag, search_busy}, 3'b100);
    tick();
    chk(rq, result_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1", {match_flag, result_valid, search_busy, table_full}, 0);
    chk("R1", next_free, 0);
  endtask

  task automatic t_basic();
    maint(2'b01, 0, 16'h1200, 16'hFF00);
    maint(2'b01, 1, 16'h1234, 16'hFFFF);
    maint(2'b01, 2, 16'hAB00, 16'hFF00);
    chk("R10", next_free, 3);
    expect_hit("R4", 16'h1234, 0);
    expect_hit("R2", 16'h12FF, 0);
    launch(16'h1234);
    tick();
    chk("R5 hold", {match_flag, result_valid, search_busy}, 3'b111);
    ack();
    chk("R5 clear", {match_flag, result_valid, search_busy}, 3'b000);
    expect_miss("R9", 16'h5555);
  endtask

  task automatic t_delete();
    maint(2'b10, 0, 0, 0);
    chk("R10", next_free, 0);
    expect_hit("R3", 16'h1234, 1);
    expect_miss("R3", 16'h12FF);
  endtask

  task automatic t_lock();
    launch(16'h1234);
    chk("R6", result_idx, 1);
    maint(2'b10, 1, 0, 0);
    maint(2'b01, 1, 16'hFFFF, 16'hFFFF);
    maint(2'b11, 1, 0, 0);
    maint(2'b01, 0, 16'h7700, 16'hFF00);
    chk("R11", {result_valid, match_flag}, 2'b11);
    chk("R11", next_free, 3);
    ack();
    expect_hit("R6", 16'h1234, 1);
    expect_hit("R11", 16'h7711, 0);
  endtask

  task automatic t_suspend();
    maint(2'b11, 2, 0, 0);
    launch(16'hAB12);
    chk("R7", {match_flag, result_valid, search_busy}, 3'b101);
    search_req = 1'b1; search_key = 16'h1234;
    tick();
    search_req = 1'b0;
    tick();
    chk("R7", {match_flag, result_valid}, 2'b10);
    maint(2'b01, 2, 16'hAB00, 16'hFF00);
    chk("R7", result_valid, 0);
    tick();
    chk("R7", {match_flag, result_valid}, 2'b11);
    chk("R8", result_idx, 2);
    ack();
  endtask

  task automatic t_full();
    for (int i = 3; i < N; i++) maint(2'b01, i, 16'hC000 + 16'(i), 16'hFFFF);
    chk("R10", table_full, 1);
    maint(2'b10, 5, 0, 0);
    chk("R10", {table_full, 3'(next_free)}, {1'b0, 3'd5});
  endtask

  task automatic t_same_edge();
    search_req = 1'b1; search_key = 16'hC003;
    tick();
    search_req = 1'b0;
    maint(2'b10, 3, 0, 0);
    chk("R12", {match_flag, result_valid}, 2'b11);
    chk("R12", result_idx, 3);
    chk("R12", next_free, 5);
    ack();
    expect_hit("R12", 16'hC003, 3);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_delete();
    t_lock();
    t_suspend();
    t_full();
    t_same_edge();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      summary();
      $finish;
    end
  end
endmodule